// File: doc/BRIEF.md
# Programmable Clock Channel Divider

This block divides a fast input clock into a channel clock. The high time and the low time are set separately, each in input-clock cycles. A small set of control registers is loaded from configuration inputs by a write strobe. The registers come out of reset with per-instance default divide values. Other controls let the channel pass the input clock straight through, hold its output at a static high level, pick whether the waveform opens with its high or its low phase, and delay the waveform start by a programmable number of cycles after a chip-level SYNC request is released. A power-down control switches the channel off.

Each channel either obeys the shared SYNC request or ignores it. While an obeying channel sees SYNC, it parks at its start level with its counters cleared. This lets a row of channels restart in a fixed phase relation to each other. New divide values never cut a phase short: each phase uses the value that was loaded when that phase began.

Top module: `clkdiv_channel`

## Requirements
- R1: After reset, with no register write, the channel starts low, drives out_en high, and divides with DEF_LOW+1 cycles low and DEF_HIGH+1 cycles high. Reset acts as a release in the sense of R3, with offset 0.
- R2: In normal division the output stays high for hi_cyc+1 input cycles and low for lo_cyc+1 input cycles, so the period is (hi_cyc+1)+(lo_cyc+1).
- R3: Number the rising edges from the release: edge 1 is the first rising edge at which the hold cause (SYNC, power-down, bypass or force) is no longer seen. The output leaves its start level at edge phase_ofs+S+2, where S is the field (hi_cyc or lo_cyc) of the start level.
- R4: While an obeying channel (sync_ign=0) sees sync_req high, its output is held at the level of start_hi (1 = high) after each edge.
- R5: With sync_ign=1, sync_req has no effect on the output waveform.
- R6: With sync_ign=1 and force_hi=1, the output is constantly high. force_hi has no effect while sync_ign=0. Clearing the force is a release in the sense of R3.
- R7: With bypass=1, clk_out follows clk. Leaving bypass is a release in the sense of R3.
- R8: With pwr_dn=1, out_en is low and clk_out is low. Clearing pwr_dn is a release in the sense of R3.
- R9: A new hi_cyc or lo_cyc value written during a phase leaves that phase's length unchanged and applies from the next phase that begins.
- R10: Configuration fields are captured only at a rising edge with cfg_we=1. At all other edges they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_req | input | 1 | Chip-level synchronization request |
| cfg_we | input | 1 | Capture the configuration fields at this edge |
| hi_cyc | input | 4 | High time minus one, in input cycles |
| lo_cyc | input | 4 | Low time minus one, in input cycles |
| phase_ofs | input | 4 | Extra wait cycles after release |
| bypass | input | 1 | Pass the input clock to the output |
| sync_ign | input | 1 | Disregard sync_req |
| force_hi | input | 1 | Static high output (needs sync_ign) |
| start_hi | input | 1 | Begin with the high phase |
| pwr_dn | input | 1 | Switch the channel off |
| clk_out | output | 1 | Divided clock |
| out_en | output | 1 | High when the output is driven, low for the off state |

## Verification
Divide settings are drawn at random, covering high time, low time, offset and start level. Each setting runs through a SYNC pulse of random length. The whole sampled waveform is compared edge by edge, so an error in the release latency is told apart from an error in the phase lengths. A long low phase that is rewritten in its middle separates latching at a phase boundary from immediate use. Junk on the fields with the strobe low shows that writes are gated. Toggling SYNC on an ignoring channel shows the request is disregarded. Force, bypass and power-down are each entered and left, and the restart waveform after each is checked.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;
  localparam int FW = 4;

  typedef struct packed {
    logic [FW-1:0] hi;
    logic [FW-1:0] lo;
    logic [FW-1:0] ofs;
    logic          byp;
    logic          ign;
    logic          frc;
    logic          sth;
    logic          pdn;
  } cdiv_cfg_t;
endpackage

// File: rtl/cdiv_cfg_regs.sv
`timescale 1ns/1ps
module cdiv_cfg_regs
  import cdiv_pkg::*;
#(
  parameter logic [FW-1:0] DEF_HIGH = 4'd7,
  parameter logic [FW-1:0] DEF_LOW  = 4'd7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  cdiv_cfg_t  d,
  output cdiv_cfg_t  q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      q.hi  <= DEF_HIGH;
      q.lo  <= DEF_LOW;
    end else if (we) begin
      q <= d;
    end
  end
endmodule

// File: rtl/cdiv_core.sv
`timescale 1ns/1ps
module cdiv_core
  import cdiv_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  cdiv_cfg_t     cfg,
  input  logic          sync_req,
  output logic          lvl,
  output logic          run,
  output logic [FW-1:0] cnt
);
  logic          force_on;
  logic          hold;
  logic [FW-1:0] lim;

  // causes that park the counter
  assign force_on = cfg.ign & cfg.frc & ~cfg.pdn & ~cfg.byp;
  assign hold     = cfg.pdn | cfg.byp | (cfg.ign & cfg.frc) |
                    (sync_req & ~cfg.ign);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= 1'b0;
      run <= 1'b0;
      cnt <= '0;
      lim <= '0;
    end else if (hold) begin
      lvl <= force_on ? 1'b1 : cfg.sth;
      run <= 1'b0;
      cnt <= '0;
    end else if (!run) begin
      lvl <= cfg.sth;
      if (cnt == cfg.ofs) begin
        run <= 1'b1;
        cnt <= '0;
        lim <= cfg.sth ? cfg.hi : cfg.lo;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (cnt == lim) begin
      lvl <= ~lvl;
      cnt <= '0;
      lim <= lvl ? cfg.lo : cfg.hi;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cdiv_out_stage.sv
`timescale 1ns/1ps
module cdiv_out_stage
  import cdiv_pkg::*;
(
  input  logic      clk,
  input  cdiv_cfg_t cfg,
  input  logic      lvl,
  output logic      clk_out,
  output logic      out_en
);
  always_comb begin
    if (cfg.pdn)      clk_out = 1'b0;
    else if (cfg.byp) clk_out = clk;
    else              clk_out = lvl;
  end
  assign out_en = ~cfg.pdn;
endmodule

// File: rtl/clkdiv_channel.sv
`timescale 1ns/1ps
module clkdiv_channel
  import cdiv_pkg::*;
#(
  parameter logic [FW-1:0] DEF_HIGH = 4'd7,
  parameter logic [FW-1:0] DEF_LOW  = 4'd7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_req,
  input  logic          cfg_we,
  input  logic [FW-1:0] hi_cyc,
  input  logic [FW-1:0] lo_cyc,
  input  logic [FW-1:0] phase_ofs,
  input  logic          bypass,
  input  logic          sync_ign,
  input  logic          force_hi,
  input  logic          start_hi,
  input  logic          pwr_dn,
  output logic          clk_out,
  output logic          out_en
);
  cdiv_cfg_t     cfg_d;
  cdiv_cfg_t     cfg_r;
  logic          core_lvl;
  logic          core_run;
  logic [FW-1:0] core_cnt;

  always_comb begin
    cfg_d.hi  = hi_cyc;
    cfg_d.lo  = lo_cyc;
    cfg_d.ofs = phase_ofs;
    cfg_d.byp = bypass;
    cfg_d.ign = sync_ign;
    cfg_d.frc = force_hi;
    cfg_d.sth = start_hi;
    cfg_d.pdn = pwr_dn;
  end

  cdiv_cfg_regs #(.DEF_HIGH(DEF_HIGH), .DEF_LOW(DEF_LOW)) u_regs (
    .clk (clk), .rst (rst), .we (cfg_we), .d (cfg_d), .q (cfg_r)
  );

  cdiv_core u_core (
    .clk (clk), .rst (rst), .cfg (cfg_r), .sync_req (sync_req),
    .lvl (core_lvl), .run (core_run), .cnt (core_cnt)
  );

  cdiv_out_stage u_out (
    .clk (clk), .cfg (cfg_r), .lvl (core_lvl),
    .clk_out (clk_out), .out_en (out_en)
  );
endmodule

// File: rtl/cdiv_chk.sv
`timescale 1ns/1ps
module cdiv_chk
  import cdiv_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          sync_req,
  input cdiv_cfg_t     cfg,
  input logic          run,
  input logic          lvl,
  input logic [FW-1:0] cnt
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  AST_SYNC_PARKS: assert property (@(posedge clk) disable iff (rst)
    (sync_req && !cfg.ign && !cfg.pdn && !cfg.byp) |=> (lvl == $past(cfg.sth))); // R4

  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (cfg.ign && cfg.frc && !cfg.pdn && !cfg.byp) |=> lvl); // R6

  AST_PDN_PARKS: assert property (@(posedge clk) disable iff (rst)
    cfg.pdn |=> (!run && cnt == '0)); // R8

  AST_EDGE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (armed && run && $past(run) && (lvl != $past(lvl))) |-> (cnt == '0)); // R2
endmodule

bind clkdiv_channel cdiv_chk u_chk (
  .clk (clk), .rst (rst), .sync_req (sync_req), .cfg (cfg_r),
  .run (core_run), .lvl (core_lvl), .cnt (core_cnt)
);

// File: tb/tb_clkdiv_channel.sv
`timescale 1ns/1ps
module tb_clkdiv_channel;
  localparam int DH = 5;
  localparam int DL = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_req = 1'b0, cfg_we = 1'b0;
  logic [3:0] hi_cyc = '0, lo_cyc = '0, phase_ofs = '0;
  logic bypass = 0, sync_ign = 0, force_hi = 0, start_hi = 0, pwr_dn = 0;
  logic clk_out, out_en;

  int n_cmp = 0, n_bad = 0;
  int c_h, c_l, c_p;
  logic c_st, c_ign, c_frc, c_byp, c_pdn;
  int unsigned seed_dummy;

  always #2 clk = ~clk;

  clkdiv_channel #(.DEF_HIGH(4'(DH)), .DEF_LOW(4'(DL))) dut (
    .clk(clk), .rst(rst), .sync_req(sync_req), .cfg_we(cfg_we),
    .hi_cyc(hi_cyc), .lo_cyc(lo_cyc), .phase_ofs(phase_ofs),
    .bypass(bypass), .sync_ign(sync_ign), .force_hi(force_hi),
    .start_hi(start_hi), .pwr_dn(pwr_dn), .clk_out(clk_out), .out_en(out_en)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(logic act, logic exp, string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // level after edge i counted from the release (edge 1)
  function automatic logic exp_lvl(int i, int p, logic st, int fl, int h, int l);
    int t0 = p + fl + 2;
    int k;
    logic v;
    if (i < t0) return st;
    k = i - t0;
    v = ~st;
    forever begin
      int len = v ? h + 1 : l + 1;
      if (k < len) return v;
      k -= len;
      v = ~v;
    end
  endfunction

  task automatic drive_cur(int h, int l);
    hi_cyc = 4'(h); lo_cyc = 4'(l); phase_ofs = 4'(c_p);
    bypass = c_byp; sync_ign = c_ign; force_hi = c_frc;
    start_hi = c_st; pwr_dn = c_pdn;
  endtask

  task automatic wr();
    drive_cur(c_h, c_l);
    cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  // n edges after a release; junk on fields unless a write is scheduled
  task automatic measure(int n, int fl, int h, int l, bit rnd_sync,
                         int chg_at, string req);
    for (int i = 1; i <= n; i++) begin
      if (i == chg_at) begin
        drive_cur(h, l);
        cfg_we = 1'b1;
      end else begin
        {hi_cyc, lo_cyc, phase_ofs} = 12'($urandom);
        {bypass, sync_ign, force_hi, start_hi, pwr_dn} = 5'($urandom);
        cfg_we = 1'b0;
      end
      sync_req = rnd_sync ? 1'($urandom) : 1'b0;
      tick();
      cfg_we = 1'b0;
      check(clk_out, exp_lvl(i, c_p, c_st, fl, h, l), req);
    end
    sync_req = 1'b0;
  endtask

  task automatic do_sync(int nhold);
    sync_req = 1'b1;
    for (int i = 0; i < nhold; i++) begin
      tick();
      check(clk_out, c_st, "R4");
    end
    sync_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'd1234);
    // R1 reset defaults
    repeat (3) tick();
    check(out_en, 1'b1, "R1");
    rst = 1'b0;
    c_h = DH; c_l = DL; c_p = 0; c_st = 0;
    c_ign = 0; c_frc = 0; c_byp = 0; c_pdn = 0;
    measure(30, DL, DH, DL, 0, 0, "R1 R10");

    // R2 R3 random settings with SYNC release
    for (int it = 0; it < 10; it++) begin
      c_h = int'($urandom % 16); c_l = int'($urandom % 16);
      c_p = int'($urandom % 16); c_st = 1'($urandom);
      wr();
      do_sync(1 + int'($urandom % 3));
      measure(c_p + 2 * (c_h + c_l + 2) + 20, c_st ? c_h : c_l,
              c_h, c_l, 0, 0, "R2 R3 R10");
    end

    // R3 directed offsets
    for (int po = 0; po < 16; po += 5) begin
      c_h = 1; c_l = 2; c_p = po; c_st = 1;
      wr();
      do_sync(2);
      measure(po + 14, c_h, c_h, c_l, 0, 0, "R3");
    end

    // R9 mid-phase rewrite
    c_h = 3; c_l = 9; c_p = 0; c_st = 0;
    wr();
    do_sync(1);
    measure(40, 9, 5, 2, 0, 3, "R9");
    c_h = 5; c_l = 2;

    // R8 power-down, then R5 on release with ignored SYNC
    c_pdn = 1; wr();
    for (int i = 0; i < 3; i++) begin
      check(out_en, 1'b0, "R8");
      check(clk_out, 1'b0, "R8");
      @(negedge clk); #1;
      check(clk_out, 1'b0, "R8");
      tick();
    end
    c_pdn = 0; c_ign = 1; c_h = 2; c_l = 4; c_p = 3; c_st = 1;
    wr();
    check(out_en, 1'b1, "R8");
    measure(40, c_h, c_h, c_l, 1, 0, "R5 R8");

    // R6 force with SYNC ignored, then release
    c_frc = 1; wr();
    for (int i = 0; i < 12; i++) begin
      sync_req = 1'($urandom);
      tick();
      check(clk_out, 1'b1, "R6");
    end
    sync_req = 1'b0;
    c_frc = 0; c_st = 0; c_p = 1; c_h = 3; c_l = 1;
    wr();
    measure(25, c_l, c_h, c_l, 0, 0, "R6");

    // R6 force has no effect while SYNC obeyed
    c_ign = 0; c_frc = 1; c_st = 0; c_p = 2; c_h = 2; c_l = 2;
    wr();
    do_sync(2);
    measure(25, c_l, c_h, c_l, 0, 0, "R6");
    c_frc = 0;

    // R7 bypass
    c_byp = 1; wr();
    for (int i = 0; i < 4; i++) begin
      check(clk_out, 1'b1, "R7");
      @(negedge clk); #1;
      check(clk_out, 1'b0, "R7");
      tick();
    end
    c_byp = 0; c_st = 1; c_p = 4; c_h = 6; c_l = 0;
    wr();
    measure(35, c_h, c_h, c_l, 0, 0, "R7");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule